// File: doc/BRIEF.md
# Conversion Result Index Capture Register

This block is a read-only status word that freezes the sequencing state of an ADC command engine whenever something notable happens. The engine reports strobes for a result being stored, an interrupt-flagged command finishing, the end of a command list, and software or hardware sequence aborts. It also reports whether a conversion is in flight. The block then captures three things: which command list was in use, which result buffer was in use, and the result index.

An abort needs its own handling. If a conversion is in flight, the captured index is either the aborted conversion's own index or the index of the last result actually stored, chosen by a store-on-abort control bit. If the engine was idle, waiting for a trigger, the index already held is kept. A software abort raises a sticky abort-done flag. A hardware abort, forced on entry to a low-power mode, updates the word but leaves that flag alone. The register has no write path.

Top module: `conv_idx_snap`

## Requirements
- R1: `snap_word` bit 15 holds the captured command-list select and bit 14 the captured result-buffer select. Bits 5:0 hold the captured result index, and bits 13:6 are always zero.
- R2: While `rst` or `soft_rst` is high, or `mod_en` is low, the register and `abort_done` are cleared to zero at each clock edge.
- R3: A cycle with `evt_flagged` high and no abort loads the live list select, buffer select and index. The value is visible right after the edge that samples the strobe.
- R4: A cycle with `evt_eol` high and no abort captures the live state in the same way as R3.
- R5: Each `evt_store` cycle records `live_idx` as the last-stored index. That value is used by later aborts.
- R6: A software abort with `conv_busy` high captures `live_idx` when `store_on_abort` is 1. When `store_on_abort` is 0, it captures the last-stored index recorded before that cycle.
- R7: A software abort with `conv_busy` low keeps the previously captured index but still loads the live list and buffer selects.
- R8: A hardware abort captures the live list and buffer selects and the last-stored index. It does not set `abort_done`.
- R9: A software abort sets `abort_done`, which stays set until an `abort_done_clr` cycle. When both occur in the same cycle, the set wins.
- R10: An abort takes precedence over `evt_flagged` and `evt_eol` in the same cycle. A software abort takes precedence over a coincident hardware abort.
- R11: A cycle with only `evt_store` (or no strobe at all) leaves `snap_word` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_en | input | 1 | Module enable; low clears the block |
| soft_rst | input | 1 | Soft reset; high clears the block |
| store_on_abort | input | 1 | Selects the aborted index (1) or the last-stored index (0) on a busy abort |
| live_list | input | 1 | Command list currently in use |
| live_buf | input | 1 | Result buffer currently in use |
| live_idx | input | 6 | Current result index |
| evt_store | input | 1 | A result was stored this cycle |
| evt_flagged | input | 1 | An interrupt-flagged command finished and its data was stored |
| evt_eol | input | 1 | End of command list reached |
| evt_sw_abort | input | 1 | Software sequence abort executed |
| evt_hw_abort | input | 1 | Hardware (low-power entry) sequence abort executed |
| conv_busy | input | 1 | A conversion is in flight |
| abort_done_clr | input | 1 | Write-one-to-clear strobe for the abort-done flag |
| snap_word | output | 16 | Captured status word |
| abort_done | output | 1 | Sticky software-abort-done flag |

## Verification
A wrong last-stored index stays hidden until an abort while busy with store-on-abort at 0, or until a hardware abort. After either one, bits 5:0 differ on the very next clock. A wrong event priority or a missed idle-hold shows up in the word one edge after the coincident strobes. A flag set on a hardware abort is visible on `abort_done` at that same edge. The stimulus therefore interleaves stores with aborts in every mode, and the word and flag are compared after every single cycle, so the failing cycle is the one that caused the error.

// File: rtl/conv_idx_pkg.sv
package conv_idx_pkg;

    localparam int unsigned IDX_W    = 6;
    localparam int unsigned WORD_W   = 16;
    localparam int unsigned LIST_POS = WORD_W - 1;
    localparam int unsigned BUF_POS  = WORD_W - 2;

    typedef struct packed {
        logic             list_sel;
        logic             buf_sel;
        logic [IDX_W-1:0] idx;
    } snap_t;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_NORMAL,
        EV_HW_ABORT,
        EV_SW_ABORT
    } evt_e;

    function automatic logic [WORD_W-1:0] pack_word(snap_t s);
        logic [WORD_W-1:0] w;
        w              = '0;
        w[LIST_POS]    = s.list_sel;
        w[BUF_POS]     = s.buf_sel;
        w[IDX_W-1:0]   = s.idx;
        return w;
    endfunction

endpackage

// File: rtl/last_store_track.sv
module last_store_track
    import conv_idx_pkg::*;
(
    input  logic             clk,
    input  logic             clr,
    input  logic             evt_store,
    input  logic [IDX_W-1:0] live_idx,
    output logic [IDX_W-1:0] last_idx
);
    always_ff @(posedge clk) begin
        if (clr)
            last_idx <= '0;
        else if (evt_store)
            last_idx <= live_idx;
    end

    // R5
    last_store_follow_chk: assert property (@(posedge clk) disable iff (clr)
        evt_store |=> last_idx == $past(live_idx));
endmodule

// File: rtl/evt_arbiter.sv
module evt_arbiter
    import conv_idx_pkg::*;
(
    input  logic evt_sw_abort,
    input  logic evt_hw_abort,
    input  logic evt_flagged,
    input  logic evt_eol,
    output evt_e kind
);
    always_comb begin
        if (evt_sw_abort)
            kind = EV_SW_ABORT;
        else if (evt_hw_abort)
            kind = EV_HW_ABORT;
        else if (evt_flagged || evt_eol)
            kind = EV_NORMAL;
        else
            kind = EV_NONE;
    end
endmodule

// File: rtl/snap_next.sv
module snap_next
    import conv_idx_pkg::*;
(
    input  evt_e             kind,
    input  logic             conv_busy,
    input  logic             store_on_abort,
    input  snap_t            live,
    input  logic [IDX_W-1:0] last_idx,
    input  snap_t            cur,
    output snap_t            nxt
);
    always_comb begin
        nxt = cur;
        case (kind)
            EV_NORMAL: nxt = live;
            EV_HW_ABORT: begin
                nxt.list_sel = live.list_sel;
                nxt.buf_sel  = live.buf_sel;
                nxt.idx      = last_idx;
            end
            EV_SW_ABORT: begin
                nxt.list_sel = live.list_sel;
                nxt.buf_sel  = live.buf_sel;
                if (conv_busy)
                    nxt.idx = store_on_abort ? live.idx : last_idx;
            end
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/conv_idx_snap.sv
module conv_idx_snap
    import conv_idx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mod_en,
    input  logic              soft_rst,
    input  logic              store_on_abort,
    input  logic              live_list,
    input  logic              live_buf,
    input  logic [IDX_W-1:0]  live_idx,
    input  logic              evt_store,
    input  logic              evt_flagged,
    input  logic              evt_eol,
    input  logic              evt_sw_abort,
    input  logic              evt_hw_abort,
    input  logic              conv_busy,
    input  logic              abort_done_clr,
    output logic [WORD_W-1:0] snap_word,
    output logic              abort_done
);
    logic             clr;
    logic [IDX_W-1:0] last_idx;
    evt_e             kind;
    snap_t            live, cur, nxt;

    assign clr  = rst || soft_rst || !mod_en;
    assign live = '{list_sel: live_list, buf_sel: live_buf, idx: live_idx};

    last_store_track u_last (
        .clk      (clk),
        .clr      (clr),
        .evt_store(evt_store),
        .live_idx (live_idx),
        .last_idx (last_idx)
    );

    evt_arbiter u_arb (
        .evt_sw_abort(evt_sw_abort),
        .evt_hw_abort(evt_hw_abort),
        .evt_flagged (evt_flagged),
        .evt_eol     (evt_eol),
        .kind        (kind)
    );

    snap_next u_next (
        .kind          (kind),
        .conv_busy     (conv_busy),
        .store_on_abort(store_on_abort),
        .live          (live),
        .last_idx      (last_idx),
        .cur           (cur),
        .nxt           (nxt)
    );

    always_ff @(posedge clk) begin
        if (clr) begin
            cur        <= '0;
            abort_done <= 1'b0;
        end else begin
            cur <= nxt;
            if (kind == EV_SW_ABORT)
                abort_done <= 1'b1;
            else if (abort_done_clr)
                abort_done <= 1'b0;
        end
    end

    assign snap_word = pack_word(cur);

    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        snap_word[BUF_POS-1:IDX_W] == '0);

    // R2
    clear_state_chk: assert property (@(posedge clk) disable iff (rst)
        (soft_rst || !mod_en) |=> (snap_word == '0 && !abort_done));

    // R3
    flagged_capture_chk: assert property (@(posedge clk) disable iff (clr)
        (evt_flagged && !evt_sw_abort && !evt_hw_abort)
        |=> snap_word[IDX_W-1:0] == $past(live_idx));

    // R7
    idle_abort_hold_chk: assert property (@(posedge clk) disable iff (clr)
        (evt_sw_abort && !conv_busy) |=> $stable(snap_word[IDX_W-1:0]));

    // R8
    hw_abort_noflag_chk: assert property (@(posedge clk) disable iff (clr)
        (evt_hw_abort && !evt_sw_abort && !abort_done) |=> !abort_done);

    // R9
    sw_abort_flag_chk: assert property (@(posedge clk) disable iff (clr)
        evt_sw_abort |=> abort_done);

    // R11
    quiet_hold_chk: assert property (@(posedge clk) disable iff (clr)
        (!evt_sw_abort && !evt_hw_abort && !evt_flagged && !evt_eol)
        |=> $stable(snap_word));
endmodule

// File: tb/conv_idx_snap_tb.sv
`timescale 1ns/1ps
module conv_idx_snap_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1, mod_en = 1'b0, soft_rst = 1'b0, store_on_abort = 1'b0;
    logic       live_list = 1'b0, live_buf = 1'b0;
    logic [5:0] live_idx = '0;
    logic       evt_store = 1'b0, evt_flagged = 1'b0, evt_eol = 1'b0;
    logic       evt_sw_abort = 1'b0, evt_hw_abort = 1'b0, conv_busy = 1'b0, abort_done_clr = 1'b0;
    logic [15:0] snap_word;
    logic        abort_done;

    int n_chk = 0, n_bad = 0;
    logic       m_list = 0, m_buf = 0, m_flag = 0;
    logic [5:0] m_idx = 0, m_last = 0;

    always #10 clk = ~clk;

    conv_idx_snap u_dut (
        .clk(clk), .rst(rst), .mod_en(mod_en), .soft_rst(soft_rst),
        .store_on_abort(store_on_abort), .live_list(live_list), .live_buf(live_buf),
        .live_idx(live_idx), .evt_store(evt_store), .evt_flagged(evt_flagged),
        .evt_eol(evt_eol), .evt_sw_abort(evt_sw_abort), .evt_hw_abort(evt_hw_abort),
        .conv_busy(conv_busy), .abort_done_clr(abort_done_clr),
        .snap_word(snap_word), .abort_done(abort_done)
    );

    function automatic logic [15:0] exp_word();
        return {m_list, m_buf, 8'h00, m_idx};
    endfunction

    function automatic string word_tag();
        if (rst || soft_rst || !mod_en) return "R2";
        if (evt_sw_abort && (evt_hw_abort || evt_flagged || evt_eol)) return "R10";
        if (evt_sw_abort) return conv_busy ? "R6" : "R7";
        if (evt_hw_abort) return (evt_flagged || evt_eol) ? "R10" : "R8";
        if (evt_flagged) return "R3";
        if (evt_eol) return "R4";
        return "R11";
    endfunction

    function automatic string flag_tag();
        if (rst || soft_rst || !mod_en) return "R2";
        if (evt_hw_abort && !evt_sw_abort) return "R8";
        return "R9";
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Called at a falling edge with inputs set; advances one cycle and checks.
    task automatic tick();
        string wt, ft;
        wt = word_tag();
        ft = flag_tag();
        if (rst || soft_rst || !mod_en) begin
            m_list = 0; m_buf = 0; m_idx = 0; m_last = 0; m_flag = 0;
        end else begin
            if (evt_sw_abort) begin
                m_list = live_list; m_buf = live_buf;
                if (conv_busy) m_idx = store_on_abort ? live_idx : m_last;
                m_flag = 1;
            end else begin
                if (evt_hw_abort) begin
                    m_list = live_list; m_buf = live_buf; m_idx = m_last;
                end else if (evt_flagged || evt_eol) begin
                    m_list = live_list; m_buf = live_buf; m_idx = live_idx;
                end
                if (abort_done_clr) m_flag = 0;
            end
            if (evt_store) m_last = live_idx;
        end
        @(posedge clk);
        @(negedge clk);
        check(wt, snap_word, exp_word());
        check(ft, {15'd0, abort_done}, {15'd0, m_flag});
        check("R1", {8'd0, snap_word[13:6]}, 16'd0);
    endtask

    task automatic quiet();
        rst = 0; soft_rst = 0; mod_en = 1;
        evt_store = 0; evt_flagged = 0; evt_eol = 0;
        evt_sw_abort = 0; evt_hw_abort = 0; abort_done_clr = 0;
    endtask

    initial begin
        #(20 * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        tick();                                   // R2 reset state
        quiet();
        // R3: flagged capture
        live_list = 1; live_buf = 0; live_idx = 6'd17; evt_flagged = 1; tick();
        // R4: end of list
        quiet(); live_list = 0; live_buf = 1; live_idx = 6'd42; evt_eol = 1; tick();
        // R5/R6: store then busy abort with store_on_abort 0 -> last stored
        quiet(); live_idx = 6'd9; evt_store = 1; tick();
        quiet(); live_idx = 6'd33; conv_busy = 1; store_on_abort = 0; evt_sw_abort = 1; tick();
        // R9: clear and set same cycle -> set wins
        quiet(); evt_sw_abort = 1; abort_done_clr = 1; live_idx = 6'd50; store_on_abort = 1; tick();
        quiet(); abort_done_clr = 1; tick();
        // R7: idle abort keeps index
        quiet(); conv_busy = 0; live_idx = 6'd2; live_list = 1; evt_sw_abort = 1; tick();
        // R8: hw abort no flag
        quiet(); abort_done_clr = 1; tick();
        quiet(); live_idx = 6'd61; evt_hw_abort = 1; evt_flagged = 1; tick();
        // R10: sw over hw and flagged
        quiet(); conv_busy = 1; store_on_abort = 1; live_idx = 6'd12;
        evt_sw_abort = 1; evt_hw_abort = 1; evt_flagged = 1; tick();
        // R11: store alone does not change word
        quiet(); live_idx = 6'd7; evt_store = 1; tick();
        // R2: soft reset and disable
        quiet(); soft_rst = 1; tick();
        quiet(); live_idx = 6'd5; evt_flagged = 1; tick();
        quiet(); mod_en = 0; tick();
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] r;
            quiet();
            r = 8'($urandom_range(0, 255));
            soft_rst       = (r < 3);
            mod_en         = !(r > 252);
            live_list      = 1'($urandom);
            live_buf       = 1'($urandom);
            live_idx       = 6'($urandom);
            conv_busy      = 1'($urandom);
            store_on_abort = 1'($urandom);
            evt_store      = ($urandom_range(0, 3) == 0);
            evt_flagged    = ($urandom_range(0, 5) == 0);
            evt_eol        = ($urandom_range(0, 9) == 0);
            evt_sw_abort   = ($urandom_range(0, 11) == 0);
            evt_hw_abort   = ($urandom_range(0, 13) == 0);
            abort_done_clr = ($urandom_range(0, 7) == 0);
            tick();
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule